// File: doc/BRIEF.md
# Shadowed Timekeeping Register Bank

This block sits between a serial command port and a set of live timekeeping counters, and it also holds a small general-purpose RAM. The port frames each transaction with a session-enable level (`ce`). While a session is open the port issues single-cycle accesses that carry a space select (time or RAM), a direction, a burst flag and a register index.

When `ce` rises, every live time register is copied into a user buffer. Every read in the session then sees one coherent instant, even while the live counters keep ticking. Time writes land only in the buffers, and each one marks its register as dirty. When `ce` falls, only the dirty registers go to the live counters as a one-cycle commit pulse. If the seconds register is among them, a prescaler-reset pulse goes out in the same cycle. A control register carries a protect flag. While that flag is set, it blocks writes to the time buffers and to the RAM, but the flag itself can still be cleared.

Top module: `rtc_shadow_bank`

## Requirements
- R1: After reset, `rdValid`, `commitValid` and `prescalerReset` are 0, and the protect flag is clear, so a read of control index 7 returns 8'h00.
- R2: On the first clock where `ce` is sampled high after being low, all seven time buffers take the value of `liveTime`. Reads of time indices 0..6 in that session return those values whatever `liveTime` does afterwards. Index 0 is seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year, and byte k sits at `liveTime[8k+7:8k]`.
- R3: On the first clock where `ce` is sampled low after being high, `commitValid` is a one-cycle pulse with bit k set exactly when time index k was written in the session. `commitData[8k+7:8k]` then holds the last value written to index k. A session with no time writes produces no pulse.
- R4: `prescalerReset` pulses in the commit cycle exactly when the seconds register (index 0) is part of the commit.
- R5: While the protect flag is set, writes to time indices 0..6 and to RAM bytes change nothing: the reads return the old values and no commit bit is set for them.
- R6: Control index 7 is always writable. Written bit 7 becomes the protect flag, and a read returns the flag in bit 7 with bits 6:0 always 0.
- R7: The RAM holds 31 bytes at indices 0..30 of the RAM space, which read back what was written. Time-space indices 8..31 and RAM index 31 read 0, and writes to them are ignored.
- R8: With `accessBurst` high, `accessAddr` is ignored and an internal pointer picks the index. The pointer is 0 at the start of every session and advances after each burst access. In the time space it wraps from 7 to 0, and in the RAM space it wraps from 30 to 0.
- R9: A read accepted at a clock edge sets `rdValid` and `rdData` for exactly the following cycle. Writes do not set `rdValid`.
- R10: Accesses are honoured only while `ce` is high and was high at the previous clock. Otherwise they have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Session enable level from the serial port |
| accessValid | input | 1 | One access this cycle |
| accessWrite | input | 1 | 1 write, 0 read |
| accessRam | input | 1 | 1 RAM space, 0 time/control space |
| accessBurst | input | 1 | Use the internal burst pointer instead of accessAddr |
| accessAddr | input | 5 | Register or byte index |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data strobe |
| liveTime | input | 56 | Live time registers, byte k is index k |
| commitValid | output | 7 | Per-register commit strobe |
| commitData | output | 56 | Values to load into the live registers |
| prescalerReset | output | 1 | Pulse when seconds is committed |

## Verification
The bench changes `liveTime` right after a session opens. A bank that copied on every cycle, or read live values directly, would return the new values instead of the frozen ones. It writes a sparse set of time registers and checks the exact commit mask, so a design that committed every buffer, or forgot to clear the dirty flags between sessions, shows up in the next commit. It sets protection and then tries time, RAM and control writes, which catches gating that is missing or that also locks the control register. It runs bursts past both wrap points and checks that out-of-range indices and accesses outside a session leave state untouched.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  parameter int ADDR_W = 5;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_TIME = 2'd1,
    RD_CTRL = 2'd2,
    RD_RAM  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic              snapshot;
    logic              commit;
    logic              timeWr;
    logic              ctrlWr;
    logic              ramWr;
    logic              rdEn;
    rdSel_e            rdSel;
    logic [ADDR_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/rtc_shadow_ctrl.sv
module rtc_shadow_ctrl
  import rtc_shadow_pkg::*;
#(
  parameter int TIME_REGS = 7,
  parameter int RAM_BYTES = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              accessValid,
  input  logic              accessWrite,
  input  logic              accessRam,
  input  logic              accessBurst,
  input  logic [ADDR_W-1:0] accessAddr,
  input  logic              wpBit,
  output strobe_t           strobes
);
  localparam int CTRL_IDX = TIME_REGS;
  localparam int RAM_LAST = RAM_BYTES - 1;

  logic              cePrev;
  logic [ADDR_W-1:0] burstPtr;
  logic [ADDR_W-1:0] effAddr;
  logic              accOk;
  logic              ceRise;
  logic              ceFall;

  assign ceRise  = ce & ~cePrev;
  assign ceFall  = ~ce & cePrev;
  assign accOk   = accessValid & ce & cePrev;
  assign effAddr = accessBurst ? burstPtr : accessAddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cePrev   <= 1'b0;
      burstPtr <= '0;
    end else begin
      cePrev <= ce;
      if (ceRise) begin
        burstPtr <= '0;
      end else if (accOk && accessBurst) begin
        if (accessRam) begin
          burstPtr <= (int'(burstPtr) >= RAM_LAST) ? '0 : burstPtr + 1'b1;
        end else begin
          burstPtr <= (int'(burstPtr) >= CTRL_IDX) ? '0 : burstPtr + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.snapshot = ceRise;
    strobes.commit   = ceFall;
    strobes.idx      = effAddr;
    strobes.rdEn     = accOk & ~accessWrite;
    strobes.rdSel    = RD_ZERO;
    if (!accessRam) begin
      if (int'(effAddr) < TIME_REGS) begin
        strobes.rdSel  = RD_TIME;
        strobes.timeWr = accOk & accessWrite & ~wpBit;
      end else if (int'(effAddr) == CTRL_IDX) begin
        strobes.rdSel  = RD_CTRL;
        strobes.ctrlWr = accOk & accessWrite;
      end
    end else if (int'(effAddr) < RAM_BYTES) begin
      strobes.rdSel = RD_RAM;
      strobes.ramWr = accOk & accessWrite & ~wpBit;
    end
  end
endmodule

// File: rtl/rtc_shadow_datapath.sv
module rtc_shadow_datapath
  import rtc_shadow_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int TIME_REGS = 7,
  parameter int RAM_BYTES = 31
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  strobe_t                     strobes,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [TIME_REGS*DATA_W-1:0] liveTime,
  output logic                        wpBit,
  output logic [DATA_W-1:0]           rdData,
  output logic                        rdValid,
  output logic [TIME_REGS-1:0]        commitValid,
  output logic [TIME_REGS*DATA_W-1:0] commitData,
  output logic                        prescalerReset
);
  localparam int IDX_W  = $clog2(TIME_REGS);
  localparam int RAM_AW = $clog2(RAM_BYTES);

  logic [DATA_W-1:0]    timeBuf [TIME_REGS];
  logic [DATA_W-1:0]    ramMem  [RAM_BYTES];
  logic [TIME_REGS-1:0] dirty;
  logic [DATA_W-1:0]    rdNext;
  logic [TIME_REGS*DATA_W-1:0] bufFlat;

  for (genvar k = 0; k < TIME_REGS; k++) begin : g_flat
    assign bufFlat[k*DATA_W +: DATA_W] = timeBuf[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TIME_REGS; k++) timeBuf[k] <= '0;
      dirty <= '0;
    end else if (strobes.snapshot) begin
      for (int k = 0; k < TIME_REGS; k++) timeBuf[k] <= liveTime[k*DATA_W +: DATA_W];
      dirty <= '0;
    end else if (strobes.commit) begin
      dirty <= '0;
    end else if (strobes.timeWr) begin
      timeBuf[strobes.idx[IDX_W-1:0]] <= wrData;
      dirty[strobes.idx[IDX_W-1:0]]   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.ramWr) ramMem[strobes.idx[RAM_AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wpBit <= 1'b0;
    end else if (strobes.ctrlWr) begin
      wpBit <= wrData[DATA_W-1];
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_TIME: rdNext = timeBuf[strobes.idx[IDX_W-1:0]];
      RD_CTRL: rdNext = {wpBit, {(DATA_W-1){1'b0}}};
      RD_RAM:  rdNext = ramMem[strobes.idx[RAM_AW-1:0]];
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdValid        <= 1'b0;
      rdData         <= '0;
      commitValid    <= '0;
      commitData     <= '0;
      prescalerReset <= 1'b0;
    end else begin
      rdValid <= strobes.rdEn;
      if (strobes.rdEn) rdData <= rdNext;
      if (strobes.commit) begin
        commitValid    <= dirty;
        commitData     <= bufFlat;
        prescalerReset <= dirty[0];
      end else begin
        commitValid    <= '0;
        prescalerReset <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank
  import rtc_shadow_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int TIME_REGS = 7,
  parameter int RAM_BYTES = 31
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ce,
  input  logic                        accessValid,
  input  logic                        accessWrite,
  input  logic                        accessRam,
  input  logic                        accessBurst,
  input  logic [ADDR_W-1:0]           accessAddr,
  input  logic [DATA_W-1:0]           wrData,
  output logic [DATA_W-1:0]           rdData,
  output logic                        rdValid,
  input  logic [TIME_REGS*DATA_W-1:0] liveTime,
  output logic [TIME_REGS-1:0]        commitValid,
  output logic [TIME_REGS*DATA_W-1:0] commitData,
  output logic                        prescalerReset
);
  strobe_t strobes;
  logic    wpBit;

  rtc_shadow_ctrl #(
    .TIME_REGS(TIME_REGS),
    .RAM_BYTES(RAM_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .accessValid(accessValid), .accessWrite(accessWrite),
    .accessRam(accessRam), .accessBurst(accessBurst),
    .accessAddr(accessAddr), .wpBit(wpBit), .strobes(strobes)
  );

  rtc_shadow_datapath #(
    .DATA_W(DATA_W),
    .TIME_REGS(TIME_REGS),
    .RAM_BYTES(RAM_BYTES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(wrData),
    .liveTime(liveTime), .wpBit(wpBit), .rdData(rdData), .rdValid(rdValid),
    .commitValid(commitValid), .commitData(commitData),
    .prescalerReset(prescalerReset)
  );
endmodule

// File: rtl/rtc_shadow_bank_chk.sv
module rtc_shadow_bank_chk #(
  parameter int DATA_W    = 8,
  parameter int TIME_REGS = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ce,
  input logic                 accessValid,
  input logic                 accessRam,
  input logic                 accessBurst,
  input logic [4:0]           accessAddr,
  input logic [DATA_W-1:0]    rdData,
  input logic                 rdValid,
  input logic [TIME_REGS-1:0] commitValid,
  input logic                 prescalerReset
);
  a_r3_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (commitValid != '0) |-> (!$past(ce) && $past(ce, 2)));

  a_r3_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    (commitValid != '0) |=> (commitValid == '0));

  a_r4_prescaler_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    prescalerReset |-> (!$past(ce) && $past(ce, 2)));

  a_r4_prescaler_single: assert property (@(posedge clk) disable iff (!rst_n)
    prescalerReset |=> !prescalerReset);

  a_r9_read_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> ($past(accessValid) && $past(ce)));

  a_r10_closed_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (accessValid && !ce) |=> !rdValid);

  a_r6_ctrl_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && !$past(accessRam) && !$past(accessBurst)
     && ($past(accessAddr) == 5'(TIME_REGS))) |-> (rdData[DATA_W-2:0] == '0));
endmodule

bind rtc_shadow_bank rtc_shadow_bank_chk #(
  .DATA_W(DATA_W),
  .TIME_REGS(TIME_REGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .accessValid(accessValid),
  .accessRam(accessRam), .accessBurst(accessBurst), .accessAddr(accessAddr),
  .rdData(rdData), .rdValid(rdValid), .commitValid(commitValid),
  .prescalerReset(prescalerReset)
);

// File: tb/rtc_shadow_bank_test.sv
module rtc_shadow_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0;
  logic        accessValid = 1'b0, accessWrite = 1'b0, accessRam = 1'b0, accessBurst = 1'b0;
  logic [4:0]  accessAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        rdValid;
  logic [55:0] liveTime = '0;
  logic [6:0]  commitValid;
  logic [55:0] commitData;
  logic        prescalerReset;

  int testCount = 0;
  int failCount = 0;
  logic [7:0] ramModel [31];
  logic [7:0] snapModel [7];

  always #2.5 clk = ~clk;

  rtc_shadow_bank uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .accessValid(accessValid),
    .accessWrite(accessWrite), .accessRam(accessRam), .accessBurst(accessBurst),
    .accessAddr(accessAddr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .liveTime(liveTime), .commitValid(commitValid), .commitData(commitData),
    .prescalerReset(prescalerReset)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic ram, input logic burst,
                     input logic [4:0] a, input logic [7:0] d,
                     output logic [7:0] q, output logic v);
    @(negedge clk);
    accessValid = 1'b1; accessWrite = wr; accessRam = ram;
    accessBurst = burst; accessAddr = a; wrData = d;
    @(negedge clk);
    accessValid = 1'b0;
    q = rdData; v = rdValid;
  endtask

  task automatic rd(input logic ram, input logic burst, input logic [4:0] a,
                    input string req, input logic [7:0] exp);
    logic [7:0] q; logic v;
    acc(1'b0, ram, burst, a, 8'h00, q, v);
    chk({req, " rdValid"}, 64'(v), 64'd1);
    chk(req, 64'(q), 64'(exp));
  endtask

  task automatic wr(input logic ram, input logic burst, input logic [4:0] a, input logic [7:0] d);
    logic [7:0] q; logic v;
    acc(1'b1, ram, burst, a, d, q, v);
    chk("R9 write gives no rdValid", 64'(v), 64'd0);
  endtask

  task automatic ceUp(input logic [55:0] live);
    @(negedge clk);
    liveTime = live; ce = 1'b1;
    for (int k = 0; k < 7; k++) snapModel[k] = live[k*8 +: 8];
    @(negedge clk);
    liveTime = ~live;
  endtask

  task automatic ceDown(output logic [6:0] cv, output logic [55:0] cd, output logic pr);
    @(negedge clk);
    ce = 1'b0;
    @(negedge clk);
    cv = commitValid; cd = commitData; pr = prescalerReset;
    @(negedge clk);
    chk("R3 commit pulse one cycle", 64'(commitValid), 64'd0);
    chk("R4 prescaler pulse one cycle", 64'(prescalerReset), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [6:0] cv; logic [55:0] cd; logic pr;
    logic [7:0] q; logic v;
    logic [55:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdValid reset", 64'(rdValid), 64'd0);
    chk("R1 commitValid reset", 64'(commitValid), 64'd0);
    chk("R1 prescalerReset reset", 64'(prescalerReset), 64'd0);

    // R10: access outside a session is ignored
    acc(1'b0, 1'b0, 1'b0, 5'd7, 8'h00, q, v);
    chk("R10 read while ce low", 64'(v), 64'd0);

    ceUp(56'h0);
    rd(1'b0, 1'b0, 5'd7, "R1 protect clear after reset", 8'h00);
    // R7: RAM sweep
    for (int a = 0; a < 31; a++) begin
      ramModel[a] = 8'((a * 37 + 11) & 8'hFF);
      wr(1'b1, 1'b0, 5'(a), ramModel[a]);
    end
    for (int a = 0; a < 31; a++) rd(1'b1, 1'b0, 5'(a), "R7 RAM readback", ramModel[a]);
    wr(1'b1, 1'b0, 5'd31, 8'hEE);
    rd(1'b1, 1'b0, 5'd31, "R7 RAM index 31 reads 0", 8'h00);
    for (int a = 8; a < 32; a++) begin
      wr(1'b0, 1'b0, 5'(a), 8'hC3);
      rd(1'b0, 1'b0, 5'(a), "R7 unused time index reads 0", 8'h00);
    end
    for (int a = 0; a < 31; a++) rd(1'b1, 1'b0, 5'(a), "R7 RAM intact after ignored writes", ramModel[a]);
    ceDown(cv, cd, pr);
    chk("R3 no time writes no commit", 64'(cv), 64'd0);

    // R10: RAM write while closed
    @(negedge clk);
    accessValid = 1'b1; accessWrite = 1'b1; accessRam = 1'b1; accessBurst = 1'b0;
    accessAddr = 5'd4; wrData = ~ramModel[4];
    @(negedge clk); accessValid = 1'b0;

    // R2/R3/R4: snapshot and sparse commit over several patterns
    for (int p = 0; p < 4; p++) begin
      pat = {8'(p*16+7), 8'(p+6), 8'(p+5), 8'(p*3+4), 8'(p+3), 8'(p*5+2), 8'(p*9+1)};
      ceUp(pat);
      if (p == 0) rd(1'b1, 1'b0, 5'd4, "R10 closed RAM write ignored", ramModel[4]);
      for (int k = 0; k < 7; k++) rd(1'b0, 1'b0, 5'(k), "R2 snapshot frozen", snapModel[k]);
      for (int k = 0; k < 7; k++) begin
        if (((p + 1) * 19 >> k) & 1) begin
          wr(1'b0, 1'b0, 5'(k), 8'(8'hA0 + k + p));
          wr(1'b0, 1'b0, 5'(k), 8'(8'h50 + k * 2 + p));
        end
      end
      ceDown(cv, cd, pr);
      chk("R3 commit mask", 64'(cv), 64'(7'(((p + 1) * 19) & 7'h7F)));
      for (int k = 0; k < 7; k++)
        if (cv[k]) chk("R3 commit data", 64'(cd[k*8 +: 8]), 64'(8'h50 + k * 2 + p));
      chk("R4 prescaler iff seconds", 64'(pr), 64'(((p + 1) * 19) & 1));
    end

    // R5/R6: write protect
    ceUp(56'h11_22_33_44_55_66_77);
    wr(1'b0, 1'b0, 5'd7, 8'hFF);
    rd(1'b0, 1'b0, 5'd7, "R6 control reads 80", 8'h80);
    wr(1'b0, 1'b0, 5'd2, 8'h99);
    wr(1'b0, 1'b0, 5'd0, 8'h98);
    wr(1'b1, 1'b0, 5'd5, 8'h97);
    rd(1'b0, 1'b0, 5'd2, "R5 protected time write", snapModel[2]);
    rd(1'b1, 1'b0, 5'd5, "R5 protected RAM write", ramModel[5]);
    ceDown(cv, cd, pr);
    chk("R5 no commit while protected", 64'(cv), 64'd0);
    chk("R5 no prescaler while protected", 64'(pr), 64'd0);
    ceUp(56'h01_02_03_04_05_06_07);
    rd(1'b0, 1'b0, 5'd7, "R6 protect persists", 8'h80);
    wr(1'b0, 1'b0, 5'd7, 8'h7F);
    rd(1'b0, 1'b0, 5'd7, "R6 control cleared", 8'h00);
    wr(1'b0, 1'b0, 5'd3, 8'h31);
    ramModel[5] = 8'h5A;
    wr(1'b1, 1'b0, 5'd5, 8'h5A);
    rd(1'b1, 1'b0, 5'd5, "R6 RAM write after clear", 8'h5A);
    ceDown(cv, cd, pr);
    chk("R6 commit after clear", 64'(cv), 64'h08);
    chk("R6 commit data after clear", 64'(cd[31:24]), 64'h31);

    // R8: clock burst past the wrap
    ceUp(56'h66_55_44_33_22_11_00);
    for (int b = 0; b < 11; b++)
      rd(1'b0, 1'b1, 5'd17, "R8 time burst", (b % 8 == 7) ? 8'h00 : snapModel[b % 8]);
    ceDown(cv, cd, pr);
    // R8: RAM burst write past the wrap, then burst read
    ceUp(56'h0);
    for (int b = 0; b < 33; b++) begin
      ramModel[b % 31] = 8'(b ^ 8'h5A);
      wr(1'b1, 1'b1, 5'd9, 8'(b ^ 8'h5A));
    end
    ceDown(cv, cd, pr);
    ceUp(56'h0);
    for (int b = 0; b < 33; b++) rd(1'b1, 1'b1, 5'd2, "R8 RAM burst", ramModel[b % 31]);
    ceDown(cv, cd, pr);
    chk("R3 burst RAM session no commit", 64'(cv), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule